// File: doc/BRIEF.md
# Two-Wire Debug Port Slave Link

This block is the slave-side link layer of a two-wire debug port. It has one clock line driven by the external master and one bidirectional data line with open-drain drivers. Both lines are brought into the system clock domain through synchronizers. The block waits for a start condition, then splits the traffic that follows into bytes of nine external clock periods each. Eight periods carry data bits, most significant bit first. The ninth period carries no bit and leaves time for internal work.

Internal logic sits above this block. It sees each received byte through a one-cycle strobe and a held byte register, and a separate one-cycle strobe marks each start condition. To answer a read, it selects the read direction and loads the byte to be sent. The block then pulls the data line low through an output enable for each zero bit. The bit is driven after each falling edge of the external clock, and the line is released in the ninth period. Command decoding happens in a separate layer above this one. The system clock must run at least four times faster than the external clock.

Top module: `dbgLinkSlave`

## Requirements
- R1: Until the first start condition after reset, the block ignores the lines. A start condition is a falling data line while the clock line is high, both as seen after synchronization. Before it, no byte is received and the data line is never driven. Each start condition raises `frameStart` for exactly one system clock.
- R2: A start condition at any point, even in the middle of a byte, returns the bit position to the first bit and discards the partly received byte.
- R3: A rising data line while the clock line is high has no effect. It is not a start condition and does not end the transfer, and byte framing continues across it.
- R4: When `readMode` is 0, a data bit is sampled on each rising edge of the clock line, first bit in the most significant position. After the eighth bit, `rxByte` holds the byte and `rxValid` is 1 for one system clock.
- R5: Each byte takes nine clock-line periods. The ninth rising edge transfers no bit, and the next rising edge carries the first bit of the next byte.
- R6: When `readMode` is 1, `lineDataOe` is updated on each falling clock edge of the first eight periods. It becomes 1 (pull the line low) when the next bit is 0 and 0 (release the line) when it is 1. Bits go most significant first, taken from the byte held at the first falling edge of the byte.
- R7: `lineDataOe` is 0 during the ninth period, right after a start condition, and whenever `readMode` is 0.
- R8: A one-cycle `txLoad` captures `txByte`. If several loads come before a read byte begins, the most recent one is the byte sent.
- R9: An edge on the lines changes the outputs exactly three system clocks after it is presented to the inputs: two synchronizer stages and one output register.
- R10: `rxByte` changes only together with `rxValid`. Read bytes and ignored activity leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineClk | input | 1 | External clock line from the master |
| lineDataIn | input | 1 | Level observed on the shared data line |
| lineDataOe | output | 1 | Open-drain enable; 1 pulls the data line low |
| readMode | input | 1 | 1: bytes are sent to the master; 0: bytes are received |
| txByte | input | 8 | Byte to send on the next read byte |
| txLoad | input | 1 | One-cycle strobe that captures `txByte` |
| rxByte | output | 8 | Most recently received byte |
| rxValid | output | 1 | One-cycle strobe: `rxByte` was just updated |
| frameStart | output | 1 | One-cycle strobe: a start condition was detected |

## Verification
A behavioural model in the bench is compared with the block on every system clock. The write stimulus uses the byte values 0xA5, 0x3C, 0x00 and 0xFF, which separate a bit-order error from a stuck or inverted line, and it first sends a full byte before any start condition to show the idle state. Two framing patterns are also tried: a start condition halfway through a byte, which separates an abort from a merge, and a rising data edge with the clock high, which separates an ignored edge from a stop or restart. Read bytes with a reloaded transmit byte confirm that the most recent load is sent, that the line is released in the ninth period, and that the received byte is left alone.

// File: rtl/dbgLinkPkg.sv
package dbgLinkPkg;

  // Strobes from the framing control to the byte datapath, one system clock each.
  typedef struct packed {
    logic startHit;   // start condition seen on synchronized lines
    logic sampleBit;  // shift the synchronized data level into the receive byte
    logic byteDone;   // this sample completes a received byte
    logic loadTx;     // first bit of a read byte: take the held transmit byte
    logic driveBit;   // put the next transmit bit on the line
    logic releaseLn;  // stop pulling the data line
  } linkStb_t;

endpackage

// File: rtl/dbgLinkSync.sv
module dbgLinkSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dbgLinkCtrl.sv
module dbgLinkCtrl
  import dbgLinkPkg::*;
#(
  parameter int BYTE_BITS = 8,
  localparam int CNT_W    = $clog2(BYTE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic             readMode,
  output linkStb_t         stb,
  output logic             armed,
  output logic [CNT_W-1:0] bitCnt
);

  logic sclP, sdaP;
  logic sclRise, sclFall, startCond;
  logic lastData, ninthSlot;

  always_comb begin
    sclRise   = sclS & ~sclP;
    sclFall   = ~sclS & sclP;
    // data falls while the clock stays high
    startCond = sclS & sclP & sdaP & ~sdaS;
    lastData  = (bitCnt == CNT_W'(BYTE_BITS - 1));
    ninthSlot = (bitCnt == CNT_W'(BYTE_BITS));
  end

  always_comb begin
    stb          = '0;
    stb.startHit = startCond;
    if (armed && !startCond) begin
      if (sclRise && !ninthSlot && !readMode) begin
        stb.sampleBit = 1'b1;
        stb.byteDone  = lastData;
      end
      if (sclFall) begin
        if (readMode && !ninthSlot) begin
          stb.driveBit = 1'b1;
          stb.loadTx   = (bitCnt == '0);
        end else begin
          stb.releaseLn = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP   <= 1'b1;
      sdaP   <= 1'b1;
      armed  <= 1'b0;
      bitCnt <= '0;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
      if (startCond) begin
        armed  <= 1'b1;
        bitCnt <= '0;
      end else if (armed && sclRise) begin
        bitCnt <= ninthSlot ? '0 : bitCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dbgLinkData.sv
module dbgLinkData
  import dbgLinkPkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  linkStb_t             stb,
  input  logic                 sdaS,
  input  logic [BYTE_BITS-1:0] txByte,
  input  logic                 txLoad,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 dataOe,
  output logic                 frameStart
);

  logic [BYTE_BITS-1:0] rxShift;
  logic [BYTE_BITS-1:0] txHold;
  logic [BYTE_BITS-1:0] txShift;
  logic [BYTE_BITS-1:0] rxNext;
  logic                 outBit;

  always_comb begin
    rxNext = {rxShift[BYTE_BITS-2:0], sdaS};
    outBit = stb.loadTx ? txHold[BYTE_BITS-1] : txShift[BYTE_BITS-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      rxByte     <= '0;
      rxValid    <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      rxValid    <= stb.byteDone;
      frameStart <= stb.startHit;
      if (stb.startHit)       rxShift <= '0;
      else if (stb.sampleBit) rxShift <= rxNext;
      if (stb.byteDone)       rxByte  <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (txLoad) txHold <= txByte;
      if (stb.startHit || stb.releaseLn) begin
        dataOe <= 1'b0;
      end else if (stb.driveBit) begin
        dataOe  <= ~outBit;
        txShift <= stb.loadTx ? {txHold[BYTE_BITS-2:0], 1'b0}
                              : {txShift[BYTE_BITS-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/dbgLinkSlave.sv
module dbgLinkSlave
  import dbgLinkPkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BYTE_BITS + 1),
  localparam int N_LINES    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineClk,
  input  logic                 lineDataIn,
  output logic                 lineDataOe,
  input  logic                 readMode,
  input  logic [BYTE_BITS-1:0] txByte,
  input  logic                 txLoad,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 frameStart
);

  logic [N_LINES-1:0] lineRaw;
  logic [N_LINES-1:0] lineSync;
  linkStb_t           ctrlStb;
  logic               lineArmed;
  logic [CNT_W-1:0]   bitCnt;

  assign lineRaw = {lineDataIn, lineClk};

  for (genvar g = 0; g < N_LINES; g++) begin : gSync
    dbgLinkSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (lineRaw[g]),
      .dout(lineSync[g])
    );
  end

  dbgLinkCtrl #(.BYTE_BITS(BYTE_BITS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclS    (lineSync[0]),
    .sdaS    (lineSync[1]),
    .readMode(readMode),
    .stb     (ctrlStb),
    .armed   (lineArmed),
    .bitCnt  (bitCnt)
  );

  dbgLinkData #(.BYTE_BITS(BYTE_BITS)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctrlStb),
    .sdaS      (lineSync[1]),
    .txByte    (txByte),
    .txLoad    (txLoad),
    .rxByte    (rxByte),
    .rxValid   (rxValid),
    .dataOe    (lineDataOe),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/dbgLinkChk.sv
module dbgLinkChk #(
  parameter int BYTE_BITS = 8,
  localparam int CNT_W    = $clog2(BYTE_BITS + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 armed,
  input logic [CNT_W-1:0]     bitCnt,
  input logic                 lineDataOe,
  input logic                 rxValid,
  input logic [BYTE_BITS-1:0] rxByte,
  input logic                 frameStart
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!rxValid && !lineDataOe && !frameStart));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (bitCnt == '0));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_BITS));

  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !lineDataOe);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxByte));

endmodule

bind dbgLinkSlave dbgLinkChk #(.BYTE_BITS(BYTE_BITS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .armed     (lineArmed),
  .bitCnt    (bitCnt),
  .lineDataOe(lineDataOe),
  .rxValid   (rxValid),
  .rxByte    (rxByte),
  .frameStart(frameStart)
);

// File: tb/dbgLinkSlave_test.sv
module dbgLinkSlave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       readMode = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       txLoad = 1'b0;
  logic       lineDataOe;
  logic [7:0] rxByte;
  logic       rxValid;
  logic       frameStart;
  logic       sdaWire;

  int checks = 0;
  int errors = 0;
  int rxPulses = 0;
  int fsPulses = 0;
  int oeWriteCycles = 0;
  bit done = 0;

  // reference model state
  int q1c = 1, q2c = 1, pc = 1, q1d = 1, q2d = 1, pd = 1;
  int mArmed = 0, mCnt = 0, mRxSh = 0, mRx = 0, mRxV = 0, mOe = 0, mFs = 0;
  int mHold = 0, mLatch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaWire = mSda & ~lineDataOe;

  dbgLinkSlave uut (
    .clk(clk), .rstN(rstN), .lineClk(mScl), .lineDataIn(sdaWire),
    .lineDataOe(lineDataOe), .readMode(readMode), .txByte(txByte),
    .txLoad(txLoad), .rxByte(rxByte), .rxValid(rxValid), .frameStart(frameStart)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int sdaIn, rise, fall, st, nRxV;
    sdaIn = int'(mSda) & (mOe ? 0 : 1);
    rise  = (q2c == 1 && pc == 0);
    fall  = (q2c == 0 && pc == 1);
    st    = (q2c == 1 && pc == 1 && pd == 1 && q2d == 0);
    nRxV  = 0;
    if (st) begin
      mArmed = 1; mCnt = 0; mOe = 0; mRxSh = 0;
    end else if (mArmed) begin
      if (rise) begin
        if (mCnt < 8) begin
          if (!readMode) begin
            mRxSh = ((mRxSh << 1) | q2d) & 255;
            if (mCnt == 7) begin mRx = mRxSh; nRxV = 1; end
          end
          mCnt++;
        end else mCnt = 0;
      end
      if (fall) begin
        if (readMode && mCnt < 8) begin
          if (mCnt == 0) mLatch = mHold;
          mOe = ((mLatch >> (7 - mCnt)) & 1) ? 0 : 1;
        end else mOe = 0;
      end
    end
    if (txLoad) mHold = txByte;
    mRxV = nRxV;
    mFs  = st;
    pc = q2c; q2c = q1c; q1c = mScl;
    pd = q2d; q2d = q1d; q1d = sdaIn;
  endtask

  // one system clock: model advances with the inputs seen at the coming edge
  task automatic cyc();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check("R9 rxValid timing", rxValid, mRxV);
    check("R10 rxByte", rxByte, mRx);
    check("R6 lineDataOe", lineDataOe, mOe);
    check("R1 frameStart", frameStart, mFs);
    if (rxValid) rxPulses++;
    if (frameStart) fsPulses++;
    if (lineDataOe && !readMode) oeWriteCycles++;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic bitPhase(input logic v, output logic seen);
    mScl = 1'b0; waitCyc(2);
    mSda = v;    waitCyc(HALF);
    mScl = 1'b1; waitCyc(HALF);
    seen = sdaWire;
  endtask

  task automatic startCond();
    mSda = 1'b1; waitCyc(HALF);
    mSda = 1'b0; waitCyc(HALF);
  endtask

  task automatic writeBits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bitPhase(b[i], s);
  endtask

  task automatic ninth();
    logic s;
    bitPhase(1'b1, s);
  endtask

  task automatic readByte(output logic [7:0] got);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitPhase(1'b1, s);
      got[i] = s;
    end
  endtask

  task automatic loadTx(input logic [7:0] b);
    txByte = b; txLoad = 1'b1; waitCyc(1);
    txLoad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int p0, f0;
    repeat (3) @(negedge clk);
    // reset state
    check("R7 reset oe", lineDataOe, 0);
    check("R4 reset rxValid", rxValid, 0);
    check("R10 reset rxByte", rxByte, 0);
    check("R1 reset frameStart", frameStart, 0);
    rstN = 1'b1;
    waitCyc(4);

    // R1: a full byte before any start condition is ignored
    writeBits(8'h5A, 8); ninth();
    check("R1 no byte before start", rxPulses, 0);
    check("R1 rxByte untouched", rxByte, 0);

    // R4: write bytes, R5: back to back across the ninth period
    startCond();
    check("R1 one start seen", fsPulses, 1);
    writeBits(8'hA5, 8); ninth();
    check("R4 byte A5", rxByte, 8'hA5);
    check("R4 one strobe", rxPulses, 1);
    writeBits(8'h3C, 8);
    check("R5 second byte 3C", rxByte, 8'h3C);

    // R3: data rises with clock high in the ninth period, framing continues
    mScl = 1'b0; waitCyc(2);
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b1; waitCyc(HALF);
    mSda = 1'b1; waitCyc(HALF);
    f0 = fsPulses;
    writeBits(8'h0F, 8); ninth();
    check("R3 byte after rising edge", rxByte, 8'h0F);
    check("R3 no extra start", fsPulses, f0);

    // R2: start in the middle of a byte aborts it
    p0 = rxPulses;
    writeBits(8'hF0, 4);
    startCond();
    writeBits(8'h81, 8); ninth();
    check("R2 byte after abort", rxByte, 8'h81);
    check("R2 single strobe", rxPulses, p0 + 1);

    // R4 extremes
    writeBits(8'h00, 8); ninth();
    check("R4 byte 00", rxByte, 8'h00);
    writeBits(8'hFF, 8); ninth();
    check("R4 byte FF", rxByte, 8'hFF);
    check("R7 no drive while writing", oeWriteCycles, 0);

    // R6, R8: read bytes, latest load wins
    p0 = rxPulses;
    readMode = 1'b1;
    loadTx(8'h11);
    loadTx(8'hC3);
    startCond();
    readByte(got);
    check("R8 read latest load C3", got, 8'hC3);
    loadTx(8'h96);
    ninth();
    check("R7 released in ninth", lineDataOe, 0);
    readByte(got);
    check("R6 read byte 96", got, 8'h96);
    ninth();
    check("R7 released after read", lineDataOe, 0);
    check("R10 rxByte kept over reads", rxByte, 8'hFF);
    check("R10 no strobe on reads", rxPulses, p0);
    readMode = 1'b0;
    waitCyc(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule